// File: doc/BRIEF.md
# ATA PIO Sector Transfer Sequencer

This block paces programmed-I/O sector transfers between a host data port and a disk-type device's sector buffer. A command names an operation, a sector count and a starting logical block address. The block then moves 16-bit words through a one-sector buffer. It fetches each sector from a backing store ahead of host reads, and it flushes each sector to the store once the host has filled it. It counts bytes transferred against the transfer length, steps the block address at every sector boundary and keeps a status byte current. It raises a one-cycle interrupt at the end of each block of sectors. A block is one sector for the plain commands and the programmed multiple count for the multiple-sector commands. The final sector always raises the interrupt.

Host writes, host reads, store fills and store drains are all valid/ready streams. A word moves only on a cycle where both valid and ready are high. Once valid is raised, it and the data stay put until the transfer takes place. The store request (address plus direction) follows the same rule. Any of these ports may hold ready low for any number of cycles. While it does, the sequencer waits, loses no data and shows busy when the stall is on the store side. A sector count of 0 means 256 sectors. Commands, the interrupt mask and the status outputs are plain level signals.

Top module: `pio_xfer_seq`

## Requirements
- R1: After reset the status is 0x40 and the error code is 0x00. Out of reset, irq, hr_valid and st_req_valid are low. Status bits used throughout are busy = bit 7, ready = bit 6, data request = bit 3 and error = bit 0.
- R2: Read commands 0x20 and 0x21 work as follows. Before any word goes out, one store read is issued per sector, in ascending address order from start_lba. Each word the store supplies is returned on hr_data in the same order. Whenever hr_valid is high the status is 0x48, and hr_data holds steady while hr_ready is low.
- R3: Write commands 0x30 and 0x31 set the status to 0x48 at once, with hw_ready high. Each sector of 256 host words is written to the store with st_req_wr = 1 at ascending addresses. The drained words equal the host words in order.
- R4: With a block size of 1, a read of N sectors raises N+1 interrupts: one as each sector becomes available and one on the final word. A write of N sectors raises N interrupts, one after each flush.
- R5: Read-multiple 0xC4 and write-multiple 0xC5 use the stored multiple count M as the block size. A read of N sectors raises ceil(N/M)+1 interrupts and a write raises ceil(N/M). A final partial block still raises one.
- R6: Set-multiple 0xC6 with a non-zero count stores that count and returns status 0x40 and error 0x00, with one interrupt. With count 0 it aborts and resets the block size to 1.
- R7: An abort, including any unrecognised command code, sets status 0x41 and error code 0x04 and raises one interrupt. The next command then runs normally.
- R8: While irq_disable is high no interrupt is raised, and the status still advances as usual.
- R9: A host write offered while no transfer is active is an overrun. The beat is taken and discarded, no store request follows, and the status becomes 0x41 with error 0x04.
- R10: The status is 0x80 (busy, no data request) while a sector is being fetched or flushed. After the last sector it is 0x40 (ready, no data request).
- R11: A stall on the store request or drain stream holds busy and the request address. The host write port is held off, and the written data still arrives intact.
- R12: A command presented while a transfer is in progress is ignored. The status and error code do not change and the transfer completes as started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 8 | Command code |
| sect_cnt | input | CNT_W | Sector count register (0 means 256) |
| start_lba | input | LBA_W | Starting logical block address |
| irq_disable | input | 1 | Interrupt mask from device control |
| hw_valid | input | 1 | Host write word valid |
| hw_ready | output | 1 | Host write word accepted |
| hw_data | input | DW | Host write word |
| hr_valid | output | 1 | Host read word valid |
| hr_ready | input | 1 | Host read word taken |
| hr_data | output | DW | Host read word |
| st_req_valid | output | 1 | Store sector request valid |
| st_req_ready | input | 1 | Store request accepted |
| st_req_wr | output | 1 | 1 = flush to store, 0 = fetch |
| st_req_lba | output | LBA_W | Sector address of the request |
| fill_valid | input | 1 | Fetched word valid |
| fill_ready | output | 1 | Fetched word accepted |
| fill_data | input | DW | Fetched word |
| drn_valid | output | 1 | Flushed word valid |
| drn_ready | input | 1 | Flushed word taken |
| drn_data | output | DW | Flushed word |
| status | output | 8 | Status byte |
| err_code | output | 8 | Error register |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets the interrupt count at block edges. It uses a five-sector multiple transfer with a block of two, so a design that skips the trailing partial block or fires on every sector gives the wrong count. It checks that set-multiple with zero really returns the block size to one, which a design that only flags the error would fail by pacing the next multiple write in twos. A host write to an idle block and a command issued in the middle of a transfer are both offered. The first must not reach the store, and the second must not disturb a transfer in flight. Stalls on the store side check that a sequencer dropping data or advancing the address under back-pressure shows up as corrupted or misaddressed drained sectors.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    K_READ,
    K_WRITE,
    K_SETMULT,
    K_BAD
  } cmd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FREQ,
    S_FILL,
    S_HOST_RD,
    S_HOST_WR,
    S_WREQ,
    S_DRAIN
  } seq_state_e;

  localparam logic [7:0] OP_RD      = 8'h20;
  localparam logic [7:0] OP_RD_NR   = 8'h21;
  localparam logic [7:0] OP_WR      = 8'h30;
  localparam logic [7:0] OP_WR_NR   = 8'h31;
  localparam logic [7:0] OP_RD_MULT = 8'hC4;
  localparam logic [7:0] OP_WR_MULT = 8'hC5;
  localparam logic [7:0] OP_SET_MUL = 8'hC6;

  localparam logic [7:0] ST_READY = 8'h40;
  localparam logic [7:0] ST_DREQ  = 8'h48;
  localparam logic [7:0] ST_BUSY  = 8'h80;
  localparam logic [7:0] ST_ABORT = 8'h41;
  localparam logic [7:0] ER_ABORT = 8'h04;
  localparam logic [7:0] ER_NONE  = 8'h00;

endpackage

// File: rtl/pio_cmd_decode.sv
module pio_cmd_decode
  import pio_pkg::*;
(
  input  logic [7:0] code,
  output cmd_kind_e  kind,
  output logic       multi
);

  always_comb begin
    kind  = K_BAD;
    multi = 1'b0;
    case (code)
      OP_RD, OP_RD_NR: kind = K_READ;
      OP_WR, OP_WR_NR: kind = K_WRITE;
      OP_RD_MULT: begin
        kind  = K_READ;
        multi = 1'b1;
      end
      OP_WR_MULT: begin
        kind  = K_WRITE;
        multi = 1'b1;
      end
      OP_SET_MUL: kind = K_SETMULT;
      default: kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/pio_sect_buf.sv
module pio_sect_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pio_blk_pacer.sv
module pio_blk_pacer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] size,
  input  logic             step,
  output logic             blk_start,
  output logic             blk_end
);

  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] size_q;
  logic             wrap;

  assign wrap      = ({1'b0, pos_q} + 1'b1) == {1'b0, size_q};
  assign blk_start = (pos_q == '0);
  assign blk_end   = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      size_q <= CNT_W'(1);
    end else if (load) begin
      pos_q  <= '0;
      size_q <= size;
    end else if (step) begin
      pos_q <= wrap ? '0 : pos_q + 1'b1;
    end
  end

endmodule

// File: rtl/pio_xfer_seq.sv
module pio_xfer_seq
  import pio_pkg::*;
#(
  parameter int DW         = 16,
  parameter int SECT_BYTES = 512,
  parameter int CNT_W      = 8,
  parameter int LBA_W      = 28,
  localparam int BEAT_B    = DW / 8,
  localparam int SECT_WDS  = SECT_BYTES / BEAT_B,
  localparam int PTR_W     = $clog2(SECT_WDS),
  localparam int BYTE_SH   = $clog2(SECT_BYTES),
  localparam int IDX_W     = CNT_W + 1 + BYTE_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic [CNT_W-1:0] sect_cnt,
  input  logic [LBA_W-1:0] start_lba,
  input  logic             irq_disable,
  input  logic             hw_valid,
  output logic             hw_ready,
  input  logic [DW-1:0]    hw_data,
  output logic             hr_valid,
  input  logic             hr_ready,
  output logic [DW-1:0]    hr_data,
  output logic             st_req_valid,
  input  logic             st_req_ready,
  output logic             st_req_wr,
  output logic [LBA_W-1:0] st_req_lba,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [DW-1:0]    fill_data,
  output logic             drn_valid,
  input  logic             drn_ready,
  output logic [DW-1:0]    drn_data,
  output logic [7:0]       status,
  output logic [7:0]       err_code,
  output logic             irq
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(SECT_WDS - 1);
  localparam logic [IDX_W-1:0] STEP_B   = IDX_W'(BEAT_B);

  seq_state_e       state, state_n;
  logic [PTR_W-1:0] wptr, wptr_n;
  logic [IDX_W-1:0] idx, idx_n, len, len_n;
  logic [LBA_W-1:0] lba, lba_n;
  logic [7:0]       status_n, err_q, err_n;
  logic [CNT_W-1:0] mult_q, mult_n;
  logic             irq_ev;

  cmd_kind_e        kind;
  logic             multi;
  logic [CNT_W:0]   tot_sect;
  logic [IDX_W-1:0] tot_bytes;

  logic             pc_load, pc_step, blk_start, blk_end;
  logic [CNT_W-1:0] pc_size;

  logic             buf_we;
  logic [DW-1:0]    buf_wdata, buf_rdata;

  logic             hw_fire, hr_fire, rq_fire, fl_fire, dr_fire;

  pio_cmd_decode u_dec (
    .code  (cmd_code),
    .kind  (kind),
    .multi (multi)
  );

  pio_blk_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pc_load),
    .size      (pc_size),
    .step      (pc_step),
    .blk_start (blk_start),
    .blk_end   (blk_end)
  );

  pio_sect_buf #(.DW(DW), .DEPTH(SECT_WDS)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (wptr),
    .wdata (buf_wdata),
    .raddr (wptr),
    .rdata (buf_rdata)
  );

  // Sector count 0 encodes the largest transfer.
  assign tot_sect  = (sect_cnt == '0) ? (CNT_W+1)'(1) << CNT_W : {1'b0, sect_cnt};
  assign tot_bytes = IDX_W'(tot_sect) << BYTE_SH;
  assign pc_size   = multi ? mult_q : CNT_W'(1);

  // Stream handshakes.
  assign hw_ready     = (state == S_HOST_WR) || ((state == S_IDLE) && !cmd_valid);
  assign hr_valid     = (state == S_HOST_RD);
  assign hr_data      = buf_rdata;
  assign st_req_valid = (state == S_FREQ) || (state == S_WREQ);
  assign st_req_wr    = (state == S_WREQ);
  assign st_req_lba   = lba;
  assign fill_ready   = (state == S_FILL);
  assign drn_valid    = (state == S_DRAIN);
  assign drn_data     = buf_rdata;
  assign err_code     = err_q;

  assign hw_fire = hw_valid && hw_ready;
  assign hr_fire = hr_valid && hr_ready;
  assign rq_fire = st_req_valid && st_req_ready;
  assign fl_fire = fill_valid && fill_ready;
  assign dr_fire = drn_valid && drn_ready;

  always_comb begin
    state_n   = state;
    wptr_n    = wptr;
    idx_n     = idx;
    len_n     = len;
    lba_n     = lba;
    status_n  = status;
    err_n     = err_q;
    mult_n    = mult_q;
    irq_ev    = 1'b0;
    pc_load   = 1'b0;
    pc_step   = 1'b0;
    buf_we    = 1'b0;
    buf_wdata = fill_data;
    case (state)
      S_IDLE: begin
        if (cmd_valid) begin
          case (kind)
            K_READ, K_WRITE: begin
              idx_n   = '0;
              len_n   = tot_bytes;
              lba_n   = start_lba;
              wptr_n  = '0;
              pc_load = 1'b1;
              err_n   = ER_NONE;
              if (kind == K_READ) begin
                state_n  = S_FREQ;
                status_n = ST_BUSY;
              end else begin
                state_n  = S_HOST_WR;
                status_n = ST_DREQ;
              end
            end
            K_SETMULT: begin
              irq_ev = 1'b1;
              if (sect_cnt == '0) begin
                mult_n   = CNT_W'(1);
                status_n = ST_ABORT;
                err_n    = ER_ABORT;
              end else begin
                mult_n   = sect_cnt;
                status_n = ST_READY;
                err_n    = ER_NONE;
              end
            end
            default: begin
              irq_ev   = 1'b1;
              status_n = ST_ABORT;
              err_n    = ER_ABORT;
            end
          endcase
        end else if (hw_fire) begin
          // Overrun: the beat is swallowed, nothing reaches the store.
          status_n = ST_ABORT;
          err_n    = ER_ABORT;
        end
      end
      S_FREQ: begin
        if (rq_fire) state_n = S_FILL;
      end
      S_FILL: begin
        if (fl_fire) begin
          buf_we = 1'b1;
          wptr_n = wptr + 1'b1;
          if (wptr == LAST_PTR) begin
            state_n  = S_HOST_RD;
            status_n = ST_DREQ;
            irq_ev   = blk_start;
          end
        end
      end
      S_HOST_RD: begin
        if (hr_fire) begin
          wptr_n = wptr + 1'b1;
          idx_n  = idx + STEP_B;
          if (wptr == LAST_PTR) begin
            pc_step = 1'b1;
            if (idx + STEP_B == len) begin
              state_n  = S_IDLE;
              status_n = ST_READY;
              irq_ev   = 1'b1;
            end else begin
              lba_n    = lba + 1'b1;
              state_n  = S_FREQ;
              status_n = ST_BUSY;
            end
          end
        end
      end
      S_HOST_WR: begin
        if (hw_fire) begin
          buf_we    = 1'b1;
          buf_wdata = hw_data;
          wptr_n    = wptr + 1'b1;
          idx_n     = idx + STEP_B;
          if (wptr == LAST_PTR) begin
            state_n  = S_WREQ;
            status_n = ST_BUSY;
          end
        end
      end
      S_WREQ: begin
        if (rq_fire) state_n = S_DRAIN;
      end
      S_DRAIN: begin
        if (dr_fire) begin
          wptr_n = wptr + 1'b1;
          if (wptr == LAST_PTR) begin
            lba_n   = lba + 1'b1;
            pc_step = 1'b1;
            if (idx == len) begin
              state_n  = S_IDLE;
              status_n = ST_READY;
              irq_ev   = 1'b1;
            end else begin
              state_n  = S_HOST_WR;
              status_n = ST_DREQ;
              irq_ev   = blk_end;
            end
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      wptr   <= '0;
      idx    <= '0;
      len    <= '0;
      lba    <= '0;
      status <= ST_READY;
      err_q  <= ER_NONE;
      mult_q <= CNT_W'(1);
      irq    <= 1'b0;
    end else begin
      state  <= state_n;
      wptr   <= wptr_n;
      idx    <= idx_n;
      len    <= len_n;
      lba    <= lba_n;
      status <= status_n;
      err_q  <= err_n;
      mult_q <= mult_n;
      irq    <= irq_ev && !irq_disable;
    end
  end

endmodule

// File: rtl/pio_xfer_seq_chk.sv
module pio_xfer_seq_chk #(
  parameter int DW    = 16,
  parameter int LBA_W = 28,
  parameter int IDX_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       status,
  input logic [7:0]       err_code,
  input logic             irq,
  input logic             irq_disable,
  input logic             hr_valid,
  input logic             hr_ready,
  input logic [DW-1:0]    hr_data,
  input logic             st_req_valid,
  input logic             st_req_ready,
  input logic [LBA_W-1:0] st_req_lba,
  input logic [IDX_W-1:0] idx,
  input logic [IDX_W-1:0] len
);

  p_busy_drq_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3]));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(irq_disable));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req_valid && !st_req_ready) |=> (st_req_valid && $stable(st_req_lba)));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_valid && !hr_ready) |=> (hr_valid && $stable(hr_data)));

  p_rd_drq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hr_valid |-> (status == 8'h48));

  p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= len);

  p_abort_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (err_code == 8'h04));

endmodule

bind pio_xfer_seq pio_xfer_seq_chk #(
  .DW(DW), .LBA_W(LBA_W), .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .status       (status),
  .err_code     (err_code),
  .irq          (irq),
  .irq_disable  (irq_disable),
  .hr_valid     (hr_valid),
  .hr_ready     (hr_ready),
  .hr_data      (hr_data),
  .st_req_valid (st_req_valid),
  .st_req_ready (st_req_ready),
  .st_req_lba   (st_req_lba),
  .idx          (idx),
  .len          (len)
);

// File: tb/tb_pio_xfer_seq.sv
`timescale 1ns/1ps
module tb_pio_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [7:0]  sect_cnt = '0;
  logic [27:0] start_lba = '0;
  logic        irq_disable = 1'b0;
  logic        hw_valid = 1'b0;
  logic        hw_ready;
  logic [15:0] hw_data = '0;
  logic        hr_valid;
  logic        hr_ready = 1'b0;
  logic [15:0] hr_data;
  logic        st_req_valid;
  logic        st_req_ready = 1'b1;
  logic        st_req_wr;
  logic [27:0] st_req_lba;
  logic        fill_valid = 1'b1;
  logic        fill_ready;
  logic [15:0] fill_data = '0;
  logic        drn_valid;
  logic        drn_ready = 1'b1;
  logic [15:0] drn_data;
  logic [7:0]  status;
  logic [7:0]  err_code;
  logic        irq;

  always #4 clk = ~clk;

  pio_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sect_cnt(sect_cnt), .start_lba(start_lba), .irq_disable(irq_disable),
    .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_data(hw_data),
    .hr_valid(hr_valid), .hr_ready(hr_ready), .hr_data(hr_data),
    .st_req_valid(st_req_valid), .st_req_ready(st_req_ready),
    .st_req_wr(st_req_wr), .st_req_lba(st_req_lba),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data),
    .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_data(drn_data),
    .status(status), .err_code(err_code), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Monitor of completed handshakes (observation only).
  int rq_n = 0, fc = 0, dn = 0, rn = 0, wn = 0, irq_n = 0, cyc = 0;
  logic [27:0] rq_lba [32];
  logic        rq_wr  [32];
  logic [15:0] drn_log [2048];
  logic [15:0] rd_log  [2048];
  logic [27:0] cur_lba = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (st_req_valid && st_req_ready) begin
      rq_lba[rq_n % 32] <= st_req_lba;
      rq_wr[rq_n % 32]  <= st_req_wr;
      rq_n    <= rq_n + 1;
      cur_lba <= st_req_lba;
      fc      <= 0;
    end else if (fill_valid && fill_ready) begin
      fc <= fc + 1;
    end
    if (drn_valid && drn_ready) begin
      drn_log[dn % 2048] <= drn_data;
      dn <= dn + 1;
    end
    if (hr_valid && hr_ready) begin
      rd_log[rn % 2048] <= hr_data;
      rn <= rn + 1;
    end
    if (hw_valid && hw_ready) wn <= wn + 1;
    if (irq) irq_n <= irq_n + 1;
  end

  function automatic logic [15:0] wpat(int k);
    return 16'(k * 13 + 165);
  endfunction

  // Store and host-write stimulus, updated away from the active edge.
  bit stall = 0;
  bit wr_on = 0;
  int wr_goal = 0;

  initial forever begin
    @(negedge clk);
    fill_data    = {cur_lba[7:0], 8'(fc)};
    fill_valid   = !stall || (cyc % 3 != 0);
    st_req_ready = !stall || (cyc % 4 == 0);
    drn_ready    = !stall || (cyc % 2 == 0);
    hw_valid     = wr_on && (wn < wr_goal);
    hw_data      = wpat(wn);
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] code, input logic [7:0] cnt, input logic [27:0] l);
    @(negedge clk);
    cmd_code  = code;
    sect_cnt  = cnt;
    start_lba = l;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(status == 8'h40, "R1 reset status", status, 8'h40);
    chk(err_code == 8'h00, "R1 reset error", err_code, 0);
    chk(!irq && !hr_valid && !st_req_valid, "R1 reset outputs idle",
        {irq, hr_valid, st_req_valid}, 0);
  endtask

  task automatic t_read(input logic [7:0] code, input int cnt, input logic [27:0] l,
                        input int exp_irq, input bit stl, input string tag);
    int r0, q0, i0, bad;
    r0 = rn; q0 = rq_n; i0 = irq_n; bad = 0;
    stall = stl;
    hr_ready = 1'b0;
    issue(code, 8'(cnt), l);
    chk(status == 8'h80, "R10 busy while fetching", status, 8'h80);
    repeat (700) @(negedge clk);
    chk(hr_valid && status == 8'h48, "R2 data request with sector ready", status, 8'h48);
    hr_ready = 1'b1;
    for (int i = 0; i < 30000 && !((rn - r0 == cnt * 256) && status == 8'h40); i++)
      @(negedge clk);
    hr_ready = 1'b0;
    stall = 0;
    repeat (4) @(negedge clk);
    chk(rn - r0 == cnt * 256, "R2 words returned", rn - r0, cnt * 256);
    for (int i = 0; i < cnt * 256; i++)
      if (rd_log[(r0 + i) % 2048] !== {8'(l + 28'(i / 256)), 8'(i % 256)}) bad++;
    chk(bad == 0, "R2 read data order", bad, 0);
    bad = 0;
    for (int k = 0; k < cnt; k++)
      if (rq_lba[(q0 + k) % 32] !== l + 28'(k) || rq_wr[(q0 + k) % 32] !== 1'b0) bad++;
    chk(bad == 0 && rq_n - q0 == cnt, "R2 fetch addresses ascend", rq_n - q0, cnt);
    chk(irq_n - i0 == exp_irq, tag, irq_n - i0, exp_irq);
    chk(status == 8'h40, "R10 ready after final sector", status, 8'h40);
  endtask

  task automatic t_write(input logic [7:0] code, input int cnt, input logic [27:0] l,
                         input int exp_irq, input bit stl, input string tag);
    int w0, d0, q0, i0, bad;
    bit saw_bp;
    w0 = wn; d0 = dn; q0 = rq_n; i0 = irq_n; bad = 0; saw_bp = 0;
    stall = stl;
    issue(code, 8'(cnt), l);
    chk(status == 8'h48 && hw_ready, "R3 data request at write start", status, 8'h48);
    wr_goal = w0 + cnt * 256;
    wr_on = 1;
    for (int i = 0; i < 30000 && !((dn - d0 == cnt * 256) && status == 8'h40); i++) begin
      @(negedge clk);
      if (status == 8'h80 && !hw_ready) saw_bp = 1;
    end
    wr_on = 0;
    stall = 0;
    repeat (4) @(negedge clk);
    chk(dn - d0 == cnt * 256, "R3 words flushed", dn - d0, cnt * 256);
    for (int i = 0; i < cnt * 256; i++)
      if (drn_log[(d0 + i) % 2048] !== wpat(w0 + i)) bad++;
    chk(bad == 0, "R3 flushed data matches host words", bad, 0);
    bad = 0;
    for (int k = 0; k < cnt; k++)
      if (rq_lba[(q0 + k) % 32] !== l + 28'(k) || rq_wr[(q0 + k) % 32] !== 1'b1) bad++;
    chk(bad == 0 && rq_n - q0 == cnt, "R3 flush addresses ascend", rq_n - q0, cnt);
    chk(irq_n - i0 == exp_irq, tag, irq_n - i0, exp_irq);
    chk(status == 8'h40, "R10 ready after final flush", status, 8'h40);
    if (stl) chk(saw_bp, "R11 busy holds host off during store stall", saw_bp, 1);
  endtask

  task automatic t_setmult(input logic [7:0] cnt);
    int i0;
    i0 = irq_n;
    issue(8'hC6, cnt, '0);
    repeat (3) @(negedge clk);
    if (cnt == 0) begin
      chk(status == 8'h41, "R6 zero multiple aborts", status, 8'h41);
      chk(err_code == 8'h04, "R6 zero multiple error code", err_code, 8'h04);
    end else begin
      chk(status == 8'h40 && err_code == 8'h00, "R6 multiple accepted", status, 8'h40);
    end
    chk(irq_n - i0 == 1, "R6 set-multiple interrupt", irq_n - i0, 1);
  endtask

  task automatic t_bad();
    int i0;
    i0 = irq_n;
    issue(8'h55, 8'd1, '0);
    repeat (3) @(negedge clk);
    chk(status == 8'h41, "R7 unknown command aborts", status, 8'h41);
    chk(err_code == 8'h04, "R7 abort error code", err_code, 8'h04);
    chk(irq_n - i0 == 1, "R7 abort interrupt", irq_n - i0, 1);
  endtask

  task automatic t_overrun();
    int w0, q0, i0;
    w0 = wn; q0 = rq_n; i0 = irq_n;
    chk(status == 8'h40, "R9 idle before overrun", status, 8'h40);
    wr_goal = wn + 1;
    wr_on = 1;
    repeat (4) @(negedge clk);
    wr_on = 0;
    repeat (4) @(negedge clk);
    chk(wn - w0 == 1, "R9 overrun beat taken", wn - w0, 1);
    chk(status == 8'h41 && err_code == 8'h04, "R9 overrun flags error", status, 8'h41);
    chk(rq_n == q0, "R9 no store request after overrun", rq_n - q0, 0);
    chk(irq_n == i0, "R9 overrun raises no interrupt", irq_n - i0, 0);
  endtask

  task automatic t_busy_cmd();
    int d0, q0;
    d0 = dn; q0 = rq_n;
    issue(8'h30, 8'd1, 28'h300);
    issue(8'h55, 8'd0, 28'h0);
    chk(status == 8'h48 && err_code == 8'h00, "R12 command ignored mid-transfer",
        status, 8'h48);
    wr_goal = wn + 256;
    wr_on = 1;
    for (int i = 0; i < 5000 && !((dn - d0 == 256) && status == 8'h40); i++)
      @(negedge clk);
    wr_on = 0;
    repeat (4) @(negedge clk);
    chk(dn - d0 == 256 && rq_lba[q0 % 32] == 28'h300, "R12 transfer completes as started",
        dn - d0, 256);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(8'h20, 3, 28'h100, 4, 0, "R4 single read interrupt count");
    t_write(8'h30, 2, 28'h200, 2, 0, "R4 single write interrupt count");
    t_write(8'h31, 2, 28'h210, 2, 1, "R4 stalled write interrupt count");
    t_read(8'h21, 1, 28'h220, 2, 1, "R4 stalled read interrupt count");
    t_setmult(8'd2);
    t_read(8'hC4, 5, 28'h400, 4, 0, "R5 read-multiple interrupt count");
    t_write(8'hC5, 5, 28'h500, 3, 0, "R5 write-multiple interrupt count");
    t_setmult(8'd0);
    t_write(8'hC5, 2, 28'h600, 2, 0, "R6 block size back to one");
    t_bad();
    t_read(8'h20, 1, 28'h700, 2, 0, "R7 command after abort");
    t_overrun();
    irq_disable = 1'b1;
    t_read(8'h20, 2, 28'h800, 0, 0, "R8 masked interrupts");
    irq_disable = 1'b0;
    t_busy_cmd();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule